// File: doc/BRIEF.md
# Interleaved SECDED Protected Memory

This block is a small on-chip memory whose every physical row carries four independent 72-bit error-correcting codewords, each protecting one 64-bit word. The codewords are not laid side by side. They are woven column by column, so neighbouring physical cells always belong to different words. A physical disturbance that upsets a short horizontal run of cells therefore spreads across several codewords, and each codeword still sees at most one bit in error.

An access carries a row index and a 2-bit word select. The word select alone drives the column steering, so the steering can settle while the row is being selected. A write encodes the 64-bit data into its codeword and rewrites only that word's 72 columns. A read gathers the word's columns, corrects a single-bit error, and reports a double-bit error. The read result appears one clock after the request. A test port XORs an arbitrary 288-bit mask into one stored row, which lets errors be injected.

Top module: `ilv_ecc_row_mem`

## Requirements
- R1: After reset is released, rd_valid, rd_corrected and rd_uncorr are all low.
- R2: A read request causes rd_valid to be high for exactly the following cycle, carrying the word last written at that row and word select. A write request never raises rd_valid.
- R3: A write changes only the selected word. The other three words of the same row read back unchanged.
- R4: Bit j (0..71) of the codeword of word w (0..3) is stored at physical column 4*j + w of its row.
- R5: A single flipped bit anywhere in a word's 72-bit codeword is corrected. The original data is returned with rd_corrected high and rd_uncorr low.
- R6: Two flipped bits in one codeword give rd_uncorr high and rd_corrected low. The data bits are returned without correction. Codeword bit 0 is the overall parity bit, and codeword bits 1, 2, 4, 8, 16, 32 and 64 are the Hamming check bits.
- R7: Any run of 1 to 4 adjacent flipped physical columns in a row leaves all four words readable with the correct data. rd_corrected is high exactly for the words that own a column in the run.
- R8: A read does not repair the stored row. A corrected error is reported again on every later read until the word is rewritten.
- R9: The test port inverts exactly the stored bits whose mask bit is set, in the row it addresses.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row index |
| req_word | input | 2 | Word select within the row |
| wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read result valid |
| rdata | output | 64 | Read data |
| rd_corrected | output | 1 | Single-bit error was corrected |
| rd_uncorr | output | 1 | Double-bit error detected |
| flip_en | input | 1 | Apply the flip mask this cycle |
| flip_row | input | ROW_W | Row targeted by the flip mask |
| flip_mask | input | 288 | Physical columns to invert |

## Verification
The bench sweeps every burst of 1 to 4 adjacent columns across a full row. A design that packs codewords side by side, or that swaps the column mapping, would then return wrong data or raise rd_uncorr for a multi-bit burst. It also flips every codeword bit of every word in turn, which catches a decoder that mis-handles the overall parity bit or the check-bit positions. Partial writes are checked against the three untouched neighbours; a design that re-encoded or cleared the whole row would corrupt them. Repeated reads after a single injection catch a design that silently scrubs storage, and paired check-bit flips catch a decoder that miscorrects a double error into a wrong word.

// File: rtl/ilv_ecc_pkg.sv
package ilv_ecc_pkg;
  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CW_W   = DATA_W + HAM_W + 1;
  localparam int WAYS   = 4;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int PHYS_W = CW_W * WAYS;

  function automatic logic is_pow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/ilv_secded_enc.sv
module ilv_secded_enc
  import ilv_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   cw
);
  always_comb begin
    logic [CW_W-1:0] c;
    logic            par;
    int              d;
    c = '0;
    d = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        c[p] = data[d];
        d++;
      end
    end
    for (int k = 0; k < HAM_W; k++) begin
      par = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) == 1) par ^= c[p];
      end
      c[1 << k] = par;
    end
    c[0] = ^c[CW_W-1:1];
    cw = c;
  end
endmodule

// File: rtl/ilv_secded_dec.sv
module ilv_secded_dec
  import ilv_ecc_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              corrected,
  output logic              uncorr
);
  logic [HAM_W-1:0] syn;
  logic             par;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw[p]) syn ^= HAM_W'(p);
    end
    par = ^cw;
  end

  always_comb begin
    fixed     = cw;
    corrected = 1'b0;
    uncorr    = 1'b0;
    if (par) begin
      if (int'(syn) < CW_W) begin
        fixed[syn] = ~cw[syn];
        corrected  = 1'b1;
      end else begin
        uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      uncorr = 1'b1;
    end
  end

  always_comb begin
    int d;
    data = '0;
    d = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        data[d] = fixed[p];
        d++;
      end
    end
  end
endmodule

// File: rtl/ilv_col_sel.sv
module ilv_col_sel
  import ilv_ecc_pkg::*;
(
  input  logic [PHYS_W-1:0] row,
  input  logic [WAY_W-1:0]  way,
  output logic [CW_W-1:0]   cw
);
  logic [CW_W-1:0] cand [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    for (genvar j = 0; j < CW_W; j++) begin : g_bit
      assign cand[w][j] = row[WAYS*j + w];
    end
  end

  assign cw = cand[way];
endmodule

// File: rtl/ilv_col_merge.sv
module ilv_col_merge
  import ilv_ecc_pkg::*;
(
  input  logic [PHYS_W-1:0] row_in,
  input  logic [CW_W-1:0]   cw,
  input  logic [WAY_W-1:0]  way,
  output logic [PHYS_W-1:0] row_out
);
  for (genvar j = 0; j < CW_W; j++) begin : g_bit
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign row_out[WAYS*j + w] = (way == WAY_W'(w)) ? cw[j] : row_in[WAYS*j + w];
    end
  end
endmodule

// File: rtl/ilv_ecc_row_mem.sv
module ilv_ecc_row_mem
  import ilv_ecc_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [WAY_W-1:0]  req_word,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_corrected,
  output logic              rd_uncorr,
  input  logic              flip_en,
  input  logic [ROW_W-1:0]  flip_row,
  input  logic [PHYS_W-1:0] flip_mask
);
  logic [PHYS_W-1:0] mem_q [ROWS];
  logic [PHYS_W-1:0] mem_d [ROWS];
  logic [ROWS-1:0]   mem_en;

  logic              wr_fire, rd_fire;
  logic [PHYS_W-1:0] acc_row, wr_base, wr_row;
  logic [CW_W-1:0]   wr_cw, rd_cw;
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr, dec_unc;

  logic              rd_valid_q, rd_valid_d;
  logic [DATA_W-1:0] rdata_q;
  logic              corr_q, corr_d, unc_q, unc_d;

  assign wr_fire = req_valid &&  req_write;
  assign rd_fire = req_valid && !req_write;
  assign acc_row = mem_q[req_row];
  assign wr_base = (flip_en && flip_row == req_row) ? (acc_row ^ flip_mask) : acc_row;

  ilv_secded_enc u_enc (.data(wdata), .cw(wr_cw));

  ilv_col_merge u_merge (
    .row_in(wr_base), .cw(wr_cw), .way(req_word), .row_out(wr_row)
  );

  ilv_col_sel u_sel (.row(acc_row), .way(req_word), .cw(rd_cw));

  ilv_secded_dec u_dec (
    .cw(rd_cw), .data(dec_data), .corrected(dec_corr), .uncorr(dec_unc)
  );

  // Storage next state: write overrides its own columns, flip applies elsewhere
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      mem_d[r]  = mem_q[r];
      mem_en[r] = 1'b0;
      if (flip_en && flip_row == ROW_W'(r)) begin
        mem_d[r]  = mem_q[r] ^ flip_mask;
        mem_en[r] = 1'b1;
      end
      if (wr_fire && req_row == ROW_W'(r)) begin
        mem_d[r]  = wr_row;
        mem_en[r] = 1'b1;
      end
    end
  end

  // Array cells carry no reset
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (mem_en[r]) mem_q[r] <= mem_d[r];
    end
  end

  // Read result next state
  always_comb begin
    rd_valid_d = rd_fire;
    corr_d     = rd_fire && dec_corr;
    unc_d      = rd_fire && dec_unc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      corr_q     <= 1'b0;
      unc_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      corr_q     <= corr_d;
      unc_q      <= unc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_fire) begin
      rdata_q <= dec_data;
    end
  end

  assign rd_valid     = rd_valid_q;
  assign rdata        = rdata_q;
  assign rd_corrected = corr_q;
  assign rd_uncorr    = unc_q;
endmodule

// File: rtl/ilv_ecc_row_mem_chk.sv
module ilv_ecc_row_mem_chk
  import ilv_ecc_pkg::*;
#(
  parameter int ROW_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ROW_W-1:0]  req_row,
  input logic [WAY_W-1:0]  req_word,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_corrected,
  input logic              rd_uncorr,
  input logic              flip_en
);
  // R2
  rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  // R2
  no_rd_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  // R5
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_corrected || rd_uncorr) |-> rd_valid);

  // R6
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_corrected && rd_uncorr));

  // R2
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !flip_en) ##1
    (req_valid && !req_write && !flip_en &&
     req_row == $past(req_row) && req_word == $past(req_word))
    |=> (rdata == $past(wdata, 2) && !rd_corrected && !rd_uncorr));
endmodule

bind ilv_ecc_row_mem ilv_ecc_row_mem_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/ilv_ecc_row_mem_bench.sv
module ilv_ecc_row_mem_bench;
  import ilv_ecc_pkg::*;
  localparam int ROWS  = 8;
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [ROW_W-1:0]  req_row, flip_row;
  logic [WAY_W-1:0]  req_word;
  logic [DATA_W-1:0] wdata;
  logic              rd_valid, rd_corrected, rd_uncorr, flip_en;
  logic [DATA_W-1:0] rdata;
  logic [PHYS_W-1:0] flip_mask;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ilv_ecc_row_mem #(.ROWS(ROWS)) u_ilv_ecc_row_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_word(req_word), .wdata(wdata),
    .rd_valid(rd_valid), .rdata(rdata), .rd_corrected(rd_corrected),
    .rd_uncorr(rd_uncorr), .flip_en(flip_en), .flip_row(flip_row),
    .flip_mask(flip_mask)
  );

  function automatic logic [DATA_W-1:0] pat(input int row, input int w);
    return {32'hC0DE_0000 + 32'(row * 16 + w), 32'h5A3C_96E1 ^ 32'(w * 32'h1111_1111)};
  endfunction

  task automatic chk(input bit ok, input string req, input string msg,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
    end
  endtask

  task automatic do_write(input int row, input int w, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_row = ROW_W'(row); req_word = WAY_W'(w); wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(!rd_valid, "R2", "write raised rd_valid", 64'(rd_valid), 64'd0);
  endtask

  task automatic do_read(input int row, input int w, input logic [DATA_W-1:0] exp,
                         input bit exp_c, input bit exp_u, input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_row = ROW_W'(row); req_word = WAY_W'(w);
    @(negedge clk);
    req_valid = 0;
    chk(rd_valid, req, "rd_valid", 64'(rd_valid), 64'd1);
    chk(rdata == exp, req, "rdata", rdata, exp);
    chk(rd_corrected == exp_c, req, "rd_corrected", 64'(rd_corrected), 64'(exp_c));
    chk(rd_uncorr == exp_u, req, "rd_uncorr", 64'(rd_uncorr), 64'(exp_u));
  endtask

  task automatic do_flip(input int row, input logic [PHYS_W-1:0] m);
    @(negedge clk);
    flip_en = 1; flip_row = ROW_W'(row); flip_mask = m;
    @(negedge clk);
    flip_en = 0; flip_mask = '0;
  endtask

  task automatic fill_row(input int row);
    for (int w = 0; w < WAYS; w++) do_write(row, w, pat(row, w));
  endtask

  task automatic t_reset;
    chk(!rd_valid && !rd_corrected && !rd_uncorr, "R1", "outputs after reset",
        {61'd0, rd_valid, rd_corrected, rd_uncorr}, 64'd0);
  endtask

  task automatic t_basic;
    for (int r = 0; r < ROWS; r++) fill_row(r);
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < WAYS; w++) do_read(r, w, pat(r, w), 0, 0, "R2");
    @(negedge clk);
    chk(!rd_valid, "R2", "rd_valid lasted one cycle", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_partial;
    do_write(3, 1, 64'hFFFF_0000_1234_ABCD);
    do_read(3, 0, pat(3, 0), 0, 0, "R3");
    do_read(3, 1, 64'hFFFF_0000_1234_ABCD, 0, 0, "R3");
    do_read(3, 2, pat(3, 2), 0, 0, "R3");
    do_read(3, 3, pat(3, 3), 0, 0, "R3");
    do_write(3, 1, pat(3, 1));
  endtask

  task automatic t_mapping;
    logic [PHYS_W-1:0] m;
    m = '0; m[4*10 + 2] = 1'b1;
    do_flip(2, m);
    for (int w = 0; w < WAYS; w++) do_read(2, w, pat(2, w), w == 2, 0, "R4");
    do_flip(2, m);
    m = '0; m[4*37 + 0] = 1'b1;
    do_flip(2, m);
    for (int w = 0; w < WAYS; w++) do_read(2, w, pat(2, w), w == 0, 0, "R4");
    do_flip(2, m);
  endtask

  task automatic t_single;
    for (int w = 0; w < WAYS; w++)
      for (int j = 0; j < CW_W; j++) begin
        logic [PHYS_W-1:0] m;
        m = '0; m[4*j + w] = 1'b1;
        do_flip(5, m);
        do_read(5, w, pat(5, w), 1, 0, "R5");
        do_flip(5, m);
      end
  endtask

  task automatic t_double;
    for (int w = 0; w < WAYS; w++) begin
      logic [PHYS_W-1:0] m;
      m = '0; m[4*1 + w] = 1'b1; m[4*2 + w] = 1'b1;
      do_flip(6, m);
      do_read(6, w, pat(6, w), 0, 1, "R6");
      do_flip(6, m);
    end
    begin
      logic [PHYS_W-1:0] m;
      m = '0; m[4*0 + 3] = 1'b1; m[4*64 + 3] = 1'b1;
      do_flip(6, m);
      do_read(6, 3, pat(6, 3), 0, 1, "R6");
      do_flip(6, m);
    end
  endtask

  task automatic t_burst;
    for (int len = 1; len <= 4; len++)
      for (int s = 0; s + len <= PHYS_W; s++) begin
        logic [PHYS_W-1:0] m;
        m = '0;
        for (int k = 0; k < len; k++) m[s + k] = 1'b1;
        do_flip(1, m);
        for (int w = 0; w < WAYS; w++) begin
          bit hit;
          hit = 0;
          for (int k = 0; k < len; k++) if ((s + k) % 4 == w) hit = 1;
          do_read(1, w, pat(1, w), hit, 0, "R7");
        end
        do_flip(1, m);
      end
  endtask

  task automatic t_persist;
    logic [PHYS_W-1:0] m;
    m = '0; m[4*50 + 1] = 1'b1;
    do_flip(4, m);
    do_read(4, 1, pat(4, 1), 1, 0, "R8");
    do_read(4, 1, pat(4, 1), 1, 0, "R8");
    do_flip(4, m);
    do_read(4, 1, pat(4, 1), 0, 0, "R9");
    do_write(4, 1, pat(4, 1));
    do_flip(4, m);
    do_write(4, 1, pat(4, 1));
    do_read(4, 1, pat(4, 1), 0, 0, "R8");
    m = '0; m[4*50 + 1] = 1'b1; m[4*51 + 2] = 1'b1;
    do_flip(4, m);
    do_read(4, 0, pat(4, 0), 0, 0, "R9");
    do_read(4, 1, pat(4, 1), 1, 0, "R9");
    do_read(4, 2, pat(4, 2), 1, 0, "R9");
    do_read(4, 3, pat(4, 3), 0, 0, "R9");
    do_read(5, 1, pat(5, 1), 0, 0, "R9");
    do_flip(4, m);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_row = '0; req_word = '0;
    wdata = '0; flip_en = 0; flip_row = '0; flip_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_mapping();
    t_single();
    t_double();
    t_burst();
    t_persist();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule